// File: doc/BRIEF.md
# Bus Reset and PS/2 Activity Detector

This block watches the two USB data lines and a PS/2 data line and raises one shared interrupt. A mode input selects the source. In USB mode the block looks for a sustained single-ended zero, which signals a bus reset. In PS/2 mode it looks for the data line held low for a long time, which signals keyboard or mouse activity. The lines are not watched on every clock. They are sampled only on a coarse periodic strobe, nominally one every 128 µs. A condition counts as qualified once it has been seen on a set number of consecutive strobe samples (two by default). Qualification therefore takes between 128 and 256 µs. The end of an event is likewise seen up to one strobe period after the line recovers.

While an event is qualified, the block drives a level that holds the device address register cleared. The interrupt is a one-clock pulse gated by an enable input. In USB mode it fires when the qualified reset ends. In PS/2 mode it fires at the moment of qualification. The line synchronisers, the transceiver and the interrupt controller sit outside this block.

Top module: `bus_event_detect`

## Requirements
- R1: While rst_n is low at a clock edge, the state is cleared. irq_pulse and addr_clr are 0 after that edge, and the latched mode becomes USB (0).
- R2: In USB mode (mode_ps2 = 0), the condition is present only when usb_dp and usb_dm are both 0. Either line alone at 0 never qualifies.
- R3: A condition qualifies when it is sampled as present on QUAL_TICKS consecutive strobe cycles (tick = 1). Any strobe sample without the condition restarts the count from zero.
- R4: addr_clr is 1 from the clock after the qualifying strobe until the clock after the first strobe that samples the condition absent.
- R5: In USB mode, irq_pulse is 1 for exactly one clock, in the cycle after the strobe that ends a qualified event. No pulse is raised when the event qualifies.
- R6: In PS/2 mode (mode_ps2 = 1), the condition is ps2_data = 0. irq_pulse is 1 for one clock, in the cycle after the qualifying strobe. No pulse is raised when the event ends.
- R7: irq_pulse is raised only if irq_en is 1 at the edge that would produce it. addr_clr does not depend on irq_en.
- R8: A clock edge at which mode_ps2 differs from the latched mode clears the count and addr_clr, produces no pulse, and latches the new mode. This takes priority over a strobe at the same edge.
- R9: On edges without a strobe, the qualification state and addr_clr do not change, whatever the lines do.
- R10: The lines of the unselected source have no effect. usb_dp and usb_dm are ignored in PS/2 mode, and ps2_data is ignored in USB mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock strobe marking a coarse sample point (nominally 128 µs) |
| usb_dp | input | 1 | Synchronised USB D+ sample |
| usb_dm | input | 1 | Synchronised USB D− sample |
| ps2_data | input | 1 | Synchronised PS/2 data sample |
| mode_ps2 | input | 1 | Source select: 0 = USB bus reset, 1 = PS/2 activity |
| irq_en | input | 1 | Interrupt enable |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| addr_clr | output | 1 | Level that holds the device address register cleared |

## Verification
The case hardest to reach from the ports is a mode switch that lands while an event is qualified, or on the same edge as a strobe. In that case the flush must win, and no pulse may leak out from a false edge of the qualified state. The directed sequences qualify an event in each mode and then flip mode_ps2 on a strobe cycle. Random phases also toggle the mode at arbitrary points within long and short line holds. A cycle-level reference model in the bench follows every edge, so a pulse or addr_clr level is compared in every clock, including the edges between strobes.

// File: rtl/bus_event_pkg.sv
// Shared types for the bus event detector.
// Assumes: nothing beyond IEEE 1800-2017.
package bus_event_pkg;
    // Event source selected by the mode input.
    typedef enum logic {
        SRC_USB = 1'b0,
        SRC_PS2 = 1'b1
    } src_e;
endpackage

// File: rtl/bed_line_cond.sv
// Line condition selector.
// What it does: reports whether the selected source currently shows its
//   event condition (SE0 for USB, low data for PS/2).
// Assumes: the inputs are already synchronised to clk.
module bed_line_cond
    import bus_event_pkg::*;
(
    input  src_e mode,
    input  logic usb_dp,
    input  logic usb_dm,
    input  logic ps2_data,
    output logic cond
);
    // Pick the line condition of the selected source.
    always_comb begin
        if (mode == SRC_PS2) cond = ~ps2_data;
        else                 cond = ~usb_dp & ~usb_dm;
    end
endmodule

// File: rtl/bed_qualifier.sv
// Tick-sampled persistence qualifier.
// What it does: counts consecutive strobe samples with the condition present
//   and holds a qualified flag. A change of mode flushes all state.
// Assumes: tick is a one-clock strobe; QUAL_TICKS >= 1.
module bed_qualifier
    import bus_event_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    input  src_e mode,
    output src_e mode_q,
    output logic flush,
    output logic active,
    output logic act_nxt
);
    localparam int unsigned CNT_W = $clog2(QUAL_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_TICKS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Flush whenever the requested mode differs from the latched one.
    assign flush = (mode != mode_q);

    // Next count: advance on a present sample (saturating), clear on absent.
    always_comb begin
        cnt_nxt = cnt;
        if (tick) begin
            if (!cond)                cnt_nxt = '0;
            else if (cnt != CNT_MAX)  cnt_nxt = cnt + 1'b1;
        end
        act_nxt = (cnt_nxt == CNT_MAX);
    end

    // State registers with synchronous reset and flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
            mode_q <= SRC_USB;
        end else if (flush) begin
            cnt    <= '0;
            active <= 1'b0;
            mode_q <= mode;
        end else begin
            cnt    <= cnt_nxt;
            active <= act_nxt;
        end
    end

    // R3: qualification only at a strobe that saw the condition
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(tick) && $past(cond)));
    // R9: no state change between strobes
    p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flush) |=> $stable(active));
    // R8: a mode change leaves the qualifier empty
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!active && cnt == '0));
endmodule

// File: rtl/bed_irq_pulse.sv
// Interrupt pulse generator.
// What it does: raises a one-clock pulse on the qualified edge that matches
//   the latched mode (end of event for USB, start for PS/2).
// Assumes: active/act_nxt come from the qualifier and follow its tick rules.
module bed_irq_pulse
    import bus_event_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic flush,
    input  src_e mode_q,
    input  logic active,
    input  logic act_nxt,
    input  logic irq_en,
    output logic irq_pulse
);
    logic edge_hit;

    // Choose the edge of the qualified state that counts for this mode.
    always_comb begin
        if (mode_q == SRC_PS2) edge_hit = ~active & act_nxt;
        else                   edge_hit = active & ~act_nxt;
    end

    // Register the gated pulse; a flush suppresses it.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= irq_en & tick & ~flush & edge_hit;
    end

    // R5: the pulse never lasts two clocks
    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    // R7: only enabled edges produce a pulse
    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(irq_en));
endmodule

// File: rtl/bus_event_detect.sv
// Bus reset / PS/2 activity detector, top level.
// What it does: qualifies the selected line condition on a coarse strobe,
//   holds the address clear while qualified, and pulses an interrupt.
// Assumes: synchronised line inputs; tick is a one-clock strobe.
module bus_event_detect
    import bus_event_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic usb_dp,
    input  logic usb_dm,
    input  logic ps2_data,
    input  logic mode_ps2,
    input  logic irq_en,
    output logic irq_pulse,
    output logic addr_clr
);
    src_e mode_in;
    src_e mode_q;
    logic cond;
    logic flush;
    logic active;
    logic act_nxt;

    // Map the raw mode bit to the source type.
    assign mode_in = src_e'(mode_ps2);

    bed_line_cond u_cond (
        .mode     (mode_in),
        .usb_dp   (usb_dp),
        .usb_dm   (usb_dm),
        .ps2_data (ps2_data),
        .cond     (cond)
    );

    bed_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cond    (cond),
        .mode    (mode_in),
        .mode_q  (mode_q),
        .flush   (flush),
        .active  (active),
        .act_nxt (act_nxt)
    );

    bed_irq_pulse u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .flush     (flush),
        .mode_q    (mode_q),
        .active    (active),
        .act_nxt   (act_nxt),
        .irq_en    (irq_en),
        .irq_pulse (irq_pulse)
    );

    // The address clear is held for the whole qualified interval.
    assign addr_clr = active;

    // R5: a USB pulse coincides with the end of the address clear
    p_usb_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && mode_q == SRC_USB) |-> $fell(addr_clr));
    // R6: a PS/2 pulse coincides with the start of the address clear
    p_ps2_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && mode_q == SRC_PS2) |-> $rose(addr_clr));
endmodule

// File: tb/bus_event_detect_tb.sv
// Self-checking bench: cycle-level reference model, directed and random stimulus.
module bus_event_detect_tb;
    localparam int QUAL = 2;
    localparam int TPER = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, usb_dp = 1'b1, usb_dm = 1'b0, ps2_data = 1'b1;
    logic mode_ps2 = 1'b0, irq_en = 1'b1;
    logic irq_pulse, addr_clr;

    int n_chk = 0, n_bad = 0, cyc = 0, irq_seen = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0;
    bit m_act = 0, m_irq = 0, m_mode = 0;

    always #10 clk = ~clk;

    bus_event_detect #(.QUAL_TICKS(QUAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .ps2_data(ps2_data), .mode_ps2(mode_ps2), .irq_en(irq_en),
        .irq_pulse(irq_pulse), .addr_clr(addr_clr)
    );

    function automatic bit cond_of(bit md, bit dp, bit dm, bit pd);
        return md ? !pd : (!dp && !dm);
    endfunction

    task automatic check(string t, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", t, what, got, exp, cyc);
        end
    endtask

    // Advance the model by one edge with the inputs now driven.
    task automatic model_adv();
        int nc;
        bit na;
        if (mode_ps2 != m_mode) begin
            m_cnt = 0; m_act = 0; m_irq = 0; m_mode = mode_ps2;
        end else if (tick) begin
            nc = cond_of(mode_ps2, usb_dp, usb_dm, ps2_data) ? ((m_cnt < QUAL) ? m_cnt + 1 : QUAL) : 0;
            na = (nc >= QUAL);
            m_irq = irq_en && (m_mode ? (!m_act && na) : (m_act && !na));
            m_cnt = nc; m_act = na;
        end else begin
            m_irq = 0;
        end
    endtask

    // One clock: compare at negedge, drive new inputs, advance model.
    task automatic step(bit dp, bit dm, bit pd, bit md, bit en);
        @(negedge clk);
        check(tag, "irq_pulse", irq_pulse, m_irq);
        check(tag, "addr_clr", addr_clr, m_act);
        if (irq_pulse) irq_seen++;
        usb_dp = dp; usb_dm = dm; ps2_data = pd; mode_ps2 = md; irq_en = en;
        tick = (cyc % TPER == TPER - 1);
        cyc++;
        model_adv();
    endtask

    task automatic hold(int ticks, bit dp, bit dm, bit pd, bit md, bit en);
        for (int i = 0; i < ticks * TPER; i++) step(dp, dm, pd, md, en);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        s = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "irq_pulse", irq_pulse, 0);
        check("R1", "addr_clr", addr_clr, 0);
        rst_n = 1'b1;
        model_adv();

        // R2: only one USB line low never qualifies
        tag = "R2";
        irq_seen = 0;
        hold(4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        hold(4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R2", "pulses on single line low", irq_seen, 0);

        // R3: one-tick SE0 alternating never qualifies
        tag = "R3";
        for (int k = 0; k < 4; k++) begin
            hold(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            hold(1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        end
        check("R3", "addr_clr after broken SE0", addr_clr, 0);

        // R4, R5: long SE0 then release gives exactly one pulse at the end
        tag = "R5";
        irq_seen = 0;
        hold(4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R4", "addr_clr during SE0", addr_clr, 1);
        check("R5", "no pulse at SE0 start", irq_seen, 0);
        hold(2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R5", "pulses at SE0 end", irq_seen, 1);
        check("R4", "addr_clr after SE0", addr_clr, 0);

        // R10: PS/2 low in USB mode ignored
        tag = "R10";
        hold(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10", "addr_clr for ps2 low in USB mode", addr_clr, 0);

        // R6: PS/2 mode, pulse at qualification only
        tag = "R6";
        hold(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        irq_seen = 0;
        hold(4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R6", "pulses during long low", irq_seen, 1);
        hold(2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R6", "pulses after release", irq_seen, 1);
        // R10: SE0 ignored in PS/2 mode
        hold(4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R10", "addr_clr for SE0 in PS/2 mode", addr_clr, 0);

        // R7: disabled interrupt, address clear still asserted
        tag = "R7";
        irq_seen = 0;
        hold(4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7", "addr_clr with irq disabled", addr_clr, 1);
        hold(2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R7", "pulses with irq disabled", irq_seen, 0);

        // R8: mode flip on a strobe cycle while qualified
        tag = "R8";
        hold(4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        irq_seen = 0;
        while (cyc % TPER != TPER - 1) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R8", "addr_clr after mode flip", addr_clr, 0);
        hold(2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R8", "pulses from mode flip", irq_seen, 0);

        // R9: line glitches between strobes do not count
        tag = "R9";
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            while (cyc % TPER != TPER - 1) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        end
        check("R9", "addr_clr with off-strobe SE0", addr_clr, 0);

        // random phases: R3 R4 R5 R6 R7 R8 R10 against the model
        tag = "R3 R4 R5 R6 R7 R8 R10 random";
        for (int p = 0; p < 400; p++) begin
            bit md, dp, dm, pd, en;
            int len;
            md = ($urandom % 8 == 0) ? !mode_ps2 : mode_ps2;
            dp = $urandom % 3 == 0 ? 1'b1 : 1'b0;
            dm = $urandom % 3 == 0 ? 1'b1 : 1'b0;
            pd = $urandom % 2;
            en = ($urandom % 5) != 0;
            len = 1 + $urandom % (4 * TPER);
            for (int i = 0; i < len; i++) step(dp, dm, pd, md, en);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule